// File: doc/BRIEF.md
# Main Oscillator Startup Timer

This block holds back a "main clock valid" indication until a main oscillator has had time to settle. It runs entirely on the always-on slow clock. Software writes a control word that turns the oscillator on and gives an 8-bit startup count. That write clears the valid flag and starts a down-counter. The counter steps once every eight slow-clock cycles and raises the flag when it reaches zero. A rising edge of the flag records an interrupt pending bit. When the mask bit is set, that pending bit drives a level interrupt. Reading the status register clears the pending bit.

An external clock can be used instead of a crystal. Software selects this by writing the bypass bit high while leaving the oscillator enable low. The main clock is then taken from the external input, and the valid flag is reported at once, with no countdown. The analog oscillator itself is not part of the block. It appears only as an enable output and an external-select output.

Top module: `osc_startup_timer`

## Requirements
- R1: After reset, every output is 0, and reads of the control, status and mask registers all return 0.
- R2: A control write (address 0) with bit 0 (enable) set drives `osc_en_o` high from the write edge. It clears `clk_ok_o` on that same edge, loads the count field (bits 15:8) and restarts the divide-by-eight prescaler from zero.
- R3: With a count N of 1 to 255, `clk_ok_o` stays low for the first 8N-1 slow-clock edges after the enabling write. It rises on edge 8N.
- R4: An enabling write with a count of 0 raises `clk_ok_o` on the first edge after the write.
- R5: A control write with enable 0 and bypass 0 drops `osc_en_o` and `clk_ok_o` and halts the countdown. `clk_ok_o` then stays low.
- R6: A control write with bypass (bit 1) = 1 and enable = 0 sets `ext_sel_o` and `clk_ok_o` on the write edge, with no countdown. If enable = 1, the bypass bit is ignored: `ext_sel_o` stays 0 and the countdown of R3 runs.
- R7: Each rising edge of the valid flag sets an interrupt pending bit (status bit 1). `irq_o` equals pending AND mask (mask register bit 0), and it rises on the same edge as `clk_ok_o`.
- R8: A status read (address 1) returns valid in bit 0, pending in bit 1, counter running in bit 2 and the remaining count in bits 15:8. The data appears on `rdata_o` one edge after the read. The read clears pending, so `irq_o` falls, and pending stays clear until the next rising edge of the valid flag.
- R9: An enabling write during a countdown restarts it, so the delay counts from the latest write.
- R10: The control and mask registers read back the whole 16-bit word last written. Address 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Slow clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en_i | input | 1 | Register write strobe |
| rd_en_i | input | 1 | Register read strobe |
| addr_i | input | 2 | Register address |
| wdata_i | input | 16 | Write data |
| rdata_o | output | 16 | Read data, registered |
| osc_en_o | output | 1 | Oscillator enable |
| ext_sel_o | output | 1 | Main clock taken from external input |
| clk_ok_o | output | 1 | Main clock valid flag |
| irq_o | output | 1 | Level interrupt |

## Verification
Every result is due a fixed number of slow-clock edges after the write or read edge that causes it. Enable, bypass, valid-clear and the pending clear after a read land on the stimulus edge itself. The read data also lands on that edge. A count of N raises the flag and the interrupt on edge 8N, and a count of 0 raises them on edge 1. The bench drives strobes on the falling edge and samples on later falling edges. It checks the flag one edge before its due edge and again on that edge, so an early or a late rise is reported.

// File: rtl/osc_pkg.sv
package osc_pkg;
  localparam int DATA_W  = 16;
  localparam int ADDR_W  = 2;
  localparam int BIT_EN  = 0;
  localparam int BIT_BYP = 1;
  localparam int CNT_LSB = 8;

  typedef enum logic [ADDR_W-1:0] {
    REG_CTRL   = 2'd0,
    REG_STATUS = 2'd1,
    REG_MASK   = 2'd2,
    REG_NONE   = 2'd3
  } reg_addr_e;
endpackage

// File: rtl/osc_prescaler.sv
module osc_prescaler #(
  parameter int PRE_W = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic clear_i,
  input  logic run_i,
  output logic tick_o
);
  localparam logic [PRE_W-1:0] PRE_LAST = {PRE_W{1'b1}};

  logic [PRE_W-1:0] pre_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) pre_q <= '0;
    else if (run_i)     pre_q <= pre_q + 1'b1;
  end

  assign tick_o = run_i && (pre_q == PRE_LAST);

  // R3: after a tick the prescaler starts a fresh period
  a_r3_prescale_wrap: assert property (@(posedge clk) disable iff (rst)
    (tick_o && !clear_i) |=> (pre_q == '0));
endmodule

// File: rtl/osc_countdown.sv
module osc_countdown #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load_i,
  input  logic             stop_i,
  input  logic [CNT_W-1:0] cnt_i,
  input  logic             tick_i,
  output logic             run_o,
  output logic [CNT_W-1:0] cnt_o,
  output logic             done_o
);
  localparam logic [CNT_W-1:0] CNT_ONE = CNT_W'(1);

  logic             run_q;
  logic [CNT_W-1:0] cnt_q;
  logic             at_end;

  assign at_end = (cnt_q == '0) || (tick_i && cnt_q == CNT_ONE);
  assign done_o = run_q && at_end && !load_i && !stop_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= 1'b0;
      cnt_q <= '0;
    end else if (load_i) begin
      run_q <= 1'b1;
      cnt_q <= cnt_i;
    end else if (stop_i) begin
      run_q <= 1'b0;
    end else if (run_q) begin
      if (at_end) begin
        run_q <= 1'b0;
        cnt_q <= '0;
      end else if (tick_i) begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end

  assign run_o = run_q;
  assign cnt_o = cnt_q;

  // R3: the count only moves on a prescaler tick
  a_r3_hold_between_ticks: assert property (@(posedge clk) disable iff (rst)
    (run_q && !load_i && !stop_i && !tick_i && cnt_q != '0) |=> $stable(cnt_q));
  // R5: a stop halts the countdown
  a_r5_stop_halts: assert property (@(posedge clk) disable iff (rst)
    (stop_i && !load_i) |=> !run_q);
  // R2: a load starts the countdown with the given count
  a_r2_load_runs: assert property (@(posedge clk) disable iff (rst)
    load_i |=> (run_q && cnt_q == $past(cnt_i)));
endmodule

// File: rtl/osc_irq.sv
module osc_irq (
  input  logic clk,
  input  logic rst,
  input  logic rise_i,
  input  logic ack_i,
  input  logic mask_i,
  output logic pend_o,
  output logic irq_o
);
  logic pend_q, irq_q, pend_next;

  assign pend_next = rise_i || (pend_q && !ack_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      pend_q <= pend_next;
      irq_q  <= pend_next && mask_i;
    end
  end

  assign pend_o = pend_q;
  assign irq_o  = irq_q;

  // R7: the interrupt is never raised without a pending event
  a_r7_irq_has_pend: assert property (@(posedge clk) disable iff (rst)
    irq_q |-> pend_q);
  // R8: an acknowledge without a new rise clears pending
  a_r8_ack_clears: assert property (@(posedge clk) disable iff (rst)
    (ack_i && !rise_i) |=> (!pend_q && !irq_q));
endmodule

// File: rtl/osc_startup_timer.sv
module osc_startup_timer
  import osc_pkg::*;
#(
  parameter int CNT_W = 8,
  parameter int PRE_W = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic              rd_en_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] rdata_o,
  output logic              osc_en_o,
  output logic              ext_sel_o,
  output logic              clk_ok_o,
  output logic              irq_o
);
  localparam int STAT_PAD = CNT_LSB - 3;

  logic [DATA_W-1:0] ctrl_q, mask_q, rdata_q;
  logic              ok_q, ok_next, ext_q;
  logic              ctrl_wr, mask_wr, stat_rd, start, halt;
  logic              tick, run, done, pend, mask_next;
  logic [CNT_W-1:0]  cnt;

  assign ctrl_wr = wr_en_i && (addr_i == REG_CTRL);
  assign mask_wr = wr_en_i && (addr_i == REG_MASK);
  assign stat_rd = rd_en_i && (addr_i == REG_STATUS);
  assign start   = ctrl_wr &&  wdata_i[BIT_EN];
  assign halt    = ctrl_wr && !wdata_i[BIT_EN];

  osc_prescaler #(.PRE_W(PRE_W)) u_pre (
    .clk(clk), .rst(rst), .clear_i(start), .run_i(run), .tick_o(tick)
  );

  osc_countdown #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst(rst), .load_i(start), .stop_i(halt),
    .cnt_i(wdata_i[CNT_LSB +: CNT_W]), .tick_i(tick),
    .run_o(run), .cnt_o(cnt), .done_o(done)
  );

  always_comb begin
    if (ctrl_wr)   ok_next = !wdata_i[BIT_EN] && wdata_i[BIT_BYP];
    else if (done) ok_next = 1'b1;
    else           ok_next = ok_q;
  end

  assign mask_next = mask_wr ? wdata_i[0] : mask_q[0];

  osc_irq u_irq (
    .clk(clk), .rst(rst), .rise_i(ok_next && !ok_q), .ack_i(stat_rd),
    .mask_i(mask_next), .pend_o(pend), .irq_o(irq_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q <= '0;
      mask_q <= '0;
      ok_q   <= 1'b0;
      ext_q  <= 1'b0;
    end else begin
      ok_q <= ok_next;
      if (ctrl_wr) begin
        ctrl_q <= wdata_i;
        ext_q  <= wdata_i[BIT_BYP] && !wdata_i[BIT_EN];
      end
      if (mask_wr) mask_q <= wdata_i;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (rd_en_i) begin
      unique case (reg_addr_e'(addr_i))
        REG_CTRL:   rdata_q <= ctrl_q;
        REG_STATUS: rdata_q <= DATA_W'({cnt, {STAT_PAD{1'b0}}, run, pend, ok_q});
        REG_MASK:   rdata_q <= mask_q;
        default:    rdata_q <= '0;
      endcase
    end
  end

  assign rdata_o   = rdata_q;
  assign osc_en_o  = ctrl_q[BIT_EN];
  assign ext_sel_o = ext_q;
  assign clk_ok_o  = ok_q;

  // R2: an enabling write clears the valid flag
  a_r2_start_clears: assert property (@(posedge clk) disable iff (rst)
    start |=> (!ok_q && osc_en_o));
  // R3: the end of the countdown sets the valid flag
  a_r3_done_sets: assert property (@(posedge clk) disable iff (rst)
    done |=> ok_q);
  // R6: external selection always reports a valid clock
  a_r6_bypass_ok: assert property (@(posedge clk) disable iff (rst)
    ext_q |-> (ok_q && !osc_en_o && !run));
  // R5: with both control bits low the flag stays low
  a_r5_off_low: assert property (@(posedge clk) disable iff (rst)
    (!ctrl_q[BIT_EN] && !ctrl_q[BIT_BYP] && !ctrl_wr) |=> !ok_q);
endmodule

// File: tb/osc_startup_timer_test.sv
module osc_startup_timer_test;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] wdata = '0;
  logic [15:0] rdata;
  logic        osc_en, ext_sel, clk_ok, irq;
  int          n_chk = 0, n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  osc_startup_timer uut (
    .clk(clk), .rst(rst), .wr_en_i(wr_en), .rd_en_i(rd_en), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .osc_en_o(osc_en), .ext_sel_o(ext_sel),
    .clk_ok_o(clk_ok), .irq_o(irq)
  );

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] d);
    @(negedge clk);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic t_reset;
    logic [15:0] d;
    chk("R1 outputs", {12'd0, osc_en, ext_sel, clk_ok, irq}, 16'h0);
    rd(2'd0, d); chk("R1 ctrl", d, 16'h0);
    rd(2'd1, d); chk("R1 status", d, 16'h0);
    rd(2'd2, d); chk("R1 mask", d, 16'h0);
  endtask

  task automatic t_count(input int n);
    wr(2'd0, {8'(n), 8'h01});
    chk("R2 enable", {15'd0, osc_en}, 16'd1);
    chk("R2 clears valid", {15'd0, clk_ok}, 16'd0);
    cyc(8*n - 1);
    chk("R3 not early", {15'd0, clk_ok}, 16'd0);
    cyc(1);
    chk("R3 on time", {15'd0, clk_ok}, 16'd1);
  endtask

  task automatic t_zero;
    wr(2'd0, 16'h0000);
    chk("R5 off", {15'd0, clk_ok}, 16'd0);
    wr(2'd0, 16'h0001);
    chk("R4 zero count", {15'd0, clk_ok}, 16'd0);
    cyc(1);
    chk("R4 zero count", {15'd0, clk_ok}, 16'd1);
  endtask

  task automatic t_stop;
    wr(2'd0, 16'h0201);
    cyc(5);
    wr(2'd0, 16'h0200);
    chk("R5 enable low", {15'd0, osc_en}, 16'd0);
    cyc(30);
    chk("R5 stays invalid", {15'd0, clk_ok}, 16'd0);
  endtask

  task automatic t_bypass;
    wr(2'd0, 16'h0002);
    chk("R6 bypass", {13'd0, osc_en, ext_sel, clk_ok}, 16'b011);
    wr(2'd0, 16'h0103);
    chk("R6 bypass ignored", {13'd0, osc_en, ext_sel, clk_ok}, 16'b100);
    cyc(7);
    chk("R6 counts anyway", {15'd0, clk_ok}, 16'd0);
    cyc(1);
    chk("R6 counts anyway", {15'd0, clk_ok}, 16'd1);
  endtask

  task automatic t_irq;
    logic [15:0] d;
    rd(2'd1, d);
    wr(2'd2, 16'h0001);
    wr(2'd0, 16'h0101);
    cyc(7);
    chk("R7 irq not early", {15'd0, irq}, 16'd0);
    cyc(1);
    chk("R7 irq with valid", {14'd0, clk_ok, irq}, 16'b11);
    rd(2'd1, d);
    chk("R8 status", d & 16'h0007, 16'h0003);
    chk("R8 irq cleared", {15'd0, irq}, 16'd0);
    cyc(4);
    rd(2'd1, d);
    chk("R8 no new pend", d & 16'h0003, 16'h0001);
    wr(2'd2, 16'h0000);
    wr(2'd0, 16'h0101);
    cyc(8);
    chk("R7 masked", {14'd0, clk_ok, irq}, 16'b10);
    rd(2'd1, d);
    chk("R7 pend when masked", d & 16'h0003, 16'h0003);
  endtask

  task automatic t_restart;
    logic [15:0] d;
    wr(2'd0, 16'h0301);
    cyc(10);
    rd(2'd1, d);
    chk("R8 running count", d & 16'hFF07, 16'h0204);
    wr(2'd0, 16'h0201);
    cyc(15);
    chk("R9 restart", {15'd0, clk_ok}, 16'd0);
    cyc(1);
    chk("R9 restart", {15'd0, clk_ok}, 16'd1);
  endtask

  task automatic t_regs;
    logic [15:0] d;
    wr(2'd0, 16'h5A04);
    rd(2'd0, d); chk("R10 ctrl", d, 16'h5A04);
    wr(2'd2, 16'hC3A5);
    rd(2'd2, d); chk("R10 mask", d, 16'hC3A5);
    rd(2'd3, d); chk("R10 empty", d, 16'h0000);
  endtask

  initial begin
    cyc(3);
    rst = 1'b0;
    t_reset();
    t_count(1);
    t_count(5);
    t_count(255);
    t_zero();
    t_stop();
    t_bypass();
    t_irq();
    t_restart();
    t_regs();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(PERIOD * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule